// File: doc/BRIEF.md
# Frame-Gated Reference Tick Counter

This block estimates the frequency of the clock it runs on by comparing that clock with a slower reference tick from a trusted oscillator. The counting window is not set by a timer. It is set by frame-start pulses, and each frame is a known, fixed number of system-clock cycles. The block counts the reference ticks that arrive during a set number of frames. With 50 frames of 313 lines × 512 cycles, the window is 8012800 system cycles. With a 61440 Hz reference tick, the system frequency is 8012800 × 61440 / count. For example, a count of 61486 means about 8006805 Hz. The division is left to whatever reads the result.

A start request arms the block. Frame pulses may have been masked before the start, so the first pulse seen after arming may be stale. That pulse is discarded, and the window opens on the pulse after it. The raw reference tick is asynchronous. It passes through a synchroniser chain and a rising-edge detector, so a tick counts once no matter how long it stays high. The counter stops at its largest value instead of wrapping, and raises a flag when it does. A clear request aborts or discards a measurement at any time.

Top module: `fgate_meter`

## Requirements
- R1: After reset, `tickCount` is 0 and both `done` and `overflow` are 0.
- R2: After a start request, the first frame pulse is discarded. Reference ticks before the second frame pulse are not counted.
- R3: The window spans FRAMES frame pulses after the opening pulse. `done` goes high in the cycle after the closing pulse (pulse number FRAMES+2 since start) and stays low before that.
- R4: Each low-to-high transition of `refTickRaw` inside the window adds exactly 1 to `tickCount`. A tick held high for several cycles still counts once.
- R5: Ticks seen while idle, before the window opens, or after `done` is set leave `tickCount` unchanged. While `done` is high, the count holds.
- R6: A tick arriving when `tickCount` is at 2^CNT_W−1 leaves the count there and sets `overflow`. `overflow` stays high until a clear or a new start.
- R7: A clear request, in any state, makes `tickCount` 0 and `done` and `overflow` 0 from the next cycle on. Later frame pulses and ticks are ignored until the next start.
- R8: A start request while armed or counting is ignored. The running measurement finishes with the same count and `done` timing as if no request had come.
- R9: A start request while idle or done zeroes `tickCount`, `done` and `overflow` from the next cycle and begins a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the clock being measured |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Single-cycle request to begin a measurement |
| clearReq | input | 1 | Single-cycle request to abort and zero the result |
| framePulse | input | 1 | Frame-start strobe in the system domain, one cycle wide |
| refTickRaw | input | 1 | Reference tick, asynchronous to `clk` |
| tickCount | output | CNT_W | Reference ticks counted in the window (saturating) |
| done | output | 1 | High once the window has closed, until clear or start |
| overflow | output | 1 | High when the count has saturated |

## Verification
Start and clear requests take effect on the output one cycle after the edge that samples them. `done` rises one cycle after the closing frame pulse is sampled. A raw tick reaches the counter on the third clock edge after it is driven, because of the two synchroniser stages and the edge register. The bench drives inputs on falling edges and samples outputs one falling edge later for the one-cycle results. It checks `done` on both sides of every frame pulse. It places every tick at least four cycles away from a frame pulse, so the three-cycle tick latency cannot move a tick across a window edge, and it reads counts only after the window has closed.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_ARMED,
    ST_COUNT,
    ST_DONE
  } meterState_t;

  typedef struct packed {
    logic zeroCount;
    logic countEn;
  } meterStrobe_t;

endpackage

// File: rtl/fgate_ctrl.sv
module fgate_ctrl
  import fgate_pkg::*;
#(
  parameter int FRAMES = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         clearReq,
  input  logic         framePulse,
  output meterStrobe_t stb,
  output logic         windowDone
);

  localparam int FW = $clog2(FRAMES + 1);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

  meterState_t state, stateNext;
  logic [FW-1:0] frameCnt, frameNext;

  always_comb begin
    stateNext = state;
    frameNext = frameCnt;
    stb = '0;
    if (clearReq) begin
      stateNext = ST_IDLE;
      frameNext = '0;
      stb.zeroCount = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startReq) begin
            stateNext = ST_SKIP;
            frameNext = '0;
            stb.zeroCount = 1'b1;
          end
        end
        ST_SKIP: begin
          if (framePulse) stateNext = ST_ARMED;
        end
        ST_ARMED: begin
          if (framePulse) begin
            stateNext = ST_COUNT;
            frameNext = '0;
          end
        end
        ST_COUNT: begin
          stb.countEn = 1'b1;
          if (framePulse) begin
            if (frameCnt == LAST_FRAME) stateNext = ST_DONE;
            else frameNext = frameCnt + 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      frameCnt <= '0;
    end else begin
      state <= stateNext;
      frameCnt <= frameNext;
    end
  end

  assign windowDone = (state == ST_DONE);

endmodule

// File: rtl/fgate_datapath.sv
module fgate_datapath
  import fgate_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTickRaw,
  input  meterStrobe_t     stb,
  output logic [CNT_W-1:0] tickCount,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncChain;
  logic prevLevel;
  logic tickEdge;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else syncChain[0] <= refTickRaw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else syncChain[i] <= syncChain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else prevLevel <= syncChain[SYNC_STAGES-1];
  end

  assign tickEdge = syncChain[SYNC_STAGES-1] & ~prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
      overflow <= 1'b0;
    end else if (stb.zeroCount) begin
      tickCount <= '0;
      overflow <= 1'b0;
    end else if (stb.countEn && tickEdge) begin
      if (tickCount == CNT_MAX) overflow <= 1'b1;
      else tickCount <= tickCount + 1'b1;
    end
  end

endmodule

// File: rtl/fgate_meter.sv
module fgate_meter
  import fgate_pkg::*;
#(
  parameter int FRAMES = 50,
  parameter int CNT_W = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             clearReq,
  input  logic             framePulse,
  input  logic             refTickRaw,
  output logic [CNT_W-1:0] tickCount,
  output logic             done,
  output logic             overflow
);

  meterStrobe_t stb;

  fgate_ctrl #(.FRAMES(FRAMES)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .startReq(startReq),
    .clearReq(clearReq),
    .framePulse(framePulse),
    .stb(stb),
    .windowDone(done)
  );

  fgate_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .refTickRaw(refTickRaw),
    .stb(stb),
    .tickCount(tickCount),
    .overflow(overflow)
  );

endmodule

// File: rtl/fgate_meter_chk.sv
module fgate_meter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             clearReq,
  input logic             framePulse,
  input logic [CNT_W-1:0] tickCount,
  input logic             done,
  input logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3: the window only closes right after a frame pulse
  p_done_after_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(framePulse));

  // R4: the count never moves by more than one per cycle
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!startReq && !clearReq) |=>
      (tickCount == $past(tickCount) || tickCount == $past(tickCount) + 1'b1));

  // R5: a finished result holds
  p_hold_when_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq && !clearReq) |=> $stable(tickCount));

  // R6: overflow is only ever reported with a saturated count
  p_sat_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (tickCount == CNT_MAX));

  // R7: clear empties the result
  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (tickCount == '0 && !done && !overflow));

  // R8: a start during an active count does not lower it
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!done && tickCount != '0 && startReq && !clearReq) |=> (tickCount >= $past(tickCount)));

  // R9: start after a finished window begins afresh
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && startReq && !clearReq) |=> (!done && tickCount == '0 && !overflow));

endmodule

bind fgate_meter fgate_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .startReq(startReq),
  .clearReq(clearReq),
  .framePulse(framePulse),
  .tickCount(tickCount),
  .done(done),
  .overflow(overflow)
);

// File: tb/fgate_meter_tb.sv
`timescale 1ns/1ps
module fgate_meter_tb;

  localparam int FRAMES = 4;
  localparam int CNT_W = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic clearReq = 1'b0;
  logic framePulse = 1'b0;
  logic refTickRaw = 1'b0;
  logic [CNT_W-1:0] tickCount;
  logic done;
  logic overflow;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fgate_meter #(.FRAMES(FRAMES), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk),
    .rstN(rstN),
    .startReq(startReq),
    .clearReq(clearReq),
    .framePulse(framePulse),
    .refTickRaw(refTickRaw),
    .tickCount(tickCount),
    .done(done),
    .overflow(overflow)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (actual cycles=%0d, expected fewer)", cycles);
      summary();
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit tickLevel(input int o, input int p, input int q, input int h);
    int s;
    if (o < 4) return 1'b0;
    s = o - 4;
    return ((s % q) < h) && ((s - (s % q) + 4) <= p - 4);
  endfunction

  function automatic int perFrame(input int p, input int q);
    return (p - 8) / q + 1;
  endfunction

  task automatic idleInputs();
    @(negedge clk);
    startReq = 1'b0;
    clearReq = 1'b0;
    framePulse = 1'b0;
    refTickRaw = 1'b0;
  endtask

  task automatic doStart(input string req);
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(req, "count after start", tickCount, 0);
    check(req, "done after start", done, 0);
    check(req, "overflow after start", overflow, 0);
  endtask

  task automatic doClear(input string req);
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    check(req, "count after clear", tickCount, 0);
    check(req, "done after clear", done, 0);
    check(req, "overflow after clear", overflow, 0);
  endtask

  // Frame 0 carries the stale pulse, frame 1 opens the window.
  task automatic runFrames(input int nFrames, input int p, input int q, input int h,
                           input int startFrame, input int clearFrame, input bit trackDone);
    for (int f = 0; f < nFrames; f++) begin
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        if (trackDone && c == 0)
          check("R3", $sformatf("done before pulse %0d", f + 1), done, (f >= FRAMES + 2));
        if (trackDone && c == 1)
          check("R3", $sformatf("done after pulse %0d", f + 1), done, (f + 1 >= FRAMES + 2));
        if (f == clearFrame && c == 21) begin
          check("R7", "count right after clear", tickCount, 0);
          check("R7", "done right after clear", done, 0);
        end
        framePulse = (c == 0);
        refTickRaw = tickLevel(c, p, q, h);
        startReq = (f == startFrame && c == 20);
        clearReq = (f == clearFrame && c == 20);
      end
    end
    idleInputs();
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1", "count at reset", tickCount, 0);
    check("R1", "done at reset", done, 0);
    check("R1", "overflow at reset", overflow, 0);
  endtask

  task automatic testIdleTicks();
    runFrames(3, 40, 8, 1, -1, -1, 1'b0);
    check("R5", "count with no start", tickCount, 0);
    check("R5", "done with no start", done, 0);
  endtask

  task automatic testBasic();
    doStart("R9");
    runFrames(FRAMES + 3, 40, 8, 1, -1, -1, 1'b1);
    check("R2", "window skips stale frame", tickCount, FRAMES * perFrame(40, 8));
    check("R5", "ticks after done ignored", tickCount, FRAMES * perFrame(40, 8));
    check("R3", "done at end", done, 1);
    check("R6", "no overflow", overflow, 0);
    doClear("R7");
  endtask

  task automatic testLongTicks();
    doStart("R9");
    runFrames(FRAMES + 2, 60, 10, 5, -1, -1, 1'b0);
    check("R4", "held-high ticks counted once", tickCount, FRAMES * perFrame(60, 10));
    check("R4", "done", done, 1);
  endtask

  task automatic testStartIgnored();
    doStart("R9");
    runFrames(FRAMES + 2, 40, 8, 1, 0, -1, 1'b0);
    check("R8", "start while armed: count", tickCount, FRAMES * perFrame(40, 8));
    check("R8", "start while armed: done", done, 1);
    doStart("R9");
    runFrames(FRAMES + 2, 40, 8, 1, 3, -1, 1'b0);
    check("R8", "start while counting: count", tickCount, FRAMES * perFrame(40, 8));
    check("R8", "start while counting: done", done, 1);
  endtask

  task automatic testClearMid();
    doStart("R9");
    runFrames(FRAMES + 2, 40, 8, 1, -1, 3, 1'b0);
    check("R7", "count stays zero after clear", tickCount, 0);
    check("R7", "done stays low after clear", done, 0);
  endtask

  task automatic testSaturate();
    doStart("R9");
    runFrames(FRAMES + 2, 200, 2, 1, -1, -1, 1'b0);
    check("R6", "count saturated", tickCount, CNT_MAX);
    check("R6", "overflow set", overflow, 1);
    check("R6", "done after saturating window", done, 1);
    doStart("R9");
    runFrames(FRAMES + 2, 40, 8, 1, -1, -1, 1'b0);
    check("R9", "fresh count after restart", tickCount, FRAMES * perFrame(40, 8));
    check("R9", "overflow stays low", overflow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testIdleTicks();
    testBasic();
    testLongTicks();
    testStartIgnored();
    testClearMid();
    testSaturate();
    summary();
  end

endmodule